// File: doc/BRIEF.md
# Floating-Point Dual-Pipe Issue Tracker

This block decides, every clock, which of two candidate floating-point operations may leave the dispatch stage. Slot 0 feeds pipe 0 and slot 1 feeds pipe 1. Each slot presents an opcode, up to three source register numbers with an enable per source, a destination register and a condition-code bit index. The tracker answers with one issue flag per slot. It also flags a slot whose operand will be taken from the forwarding path rather than the register file.

Internally it holds a countdown per floating-point register, measuring cycles until the pending result can be read. It holds a second countdown per pipe, measuring cycles the pipe stays occupied by an iterative operation. Short moves may slip past a running iterative operation; compares may not. Operations flow in order: slot 1 never passes slot 0. A slot-1 operation that depends on slot 0 in the same cycle is held back.

Top module: `fpi_issue_tracker`

## Requirements
- R1: After reset every register is readable and both pipes are idle, so any valid operation issues at once; issue_o is never high for a slot whose vld_i is low.
- R2: Opcode encoding (4 bits): 0 move, 1 negate/absolute, 2 compare, 3 conditional move reading a condition-code bit, 4 add/subtract, 5 multiply, 6 multiply-add, 7 convert, 8 divide single, 9 divide double, 10 square root single, 11 square root double, 12 reciprocal single, 13 reciprocal double, 14 reciprocal square root single, 15 reciprocal square root double. Codes 0..3 are short, 4..7 regular and 8..15 long. A short result is readable by an operation presented in the next cycle.
- R3: A regular operation has latency 4. A dependent operation may issue 3 cycles after its producer, and bypass_o is then high for that slot. bypass_o is high only on an issuing slot that takes at least one operand by forwarding.
- R4: Long latencies, in cycles from the producer's issue to the earliest dependent issue: 14, 20, 14, 23, 8, 14, 8, 17 for codes 8 to 15.
- R5: A long operation keeps its pipe busy for its staging time: 11, 17, 11, 20, 5, 11, 5, 14 cycles for codes 8 to 15. During that time regular, long and compare operations on that pipe wait.
- R6: Short operations other than compares issue on a busy pipe without waiting.
- R7: An operation whose destination register still has a pending result waits until that result is readable. Compares write no floating-point register and are exempt.
- R8: In the same cycle, slot 1 waits if it reads or writes the register written by an issuing slot-0 operation. It also waits if slot 0 issues a compare to the condition-code bit that a slot-1 conditional move reads.
- R9: Slot 1 issues only if slot 0 issues or slot 0 is not valid.
- R10: A source whose enable bit is low is ignored for hazard checks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 2 | Candidate valid per slot |
| op_i | input | 2x4 | Opcode per slot |
| src_i | input | 2x3x5 | Source register numbers per slot |
| src_en_i | input | 2x3 | Source enables per slot |
| dst_i | input | 2x5 | Destination register per slot |
| cc_i | input | 2x3 | Condition-code bit index per slot |
| issue_o | output | 2 | Slot issues this cycle |
| bypass_o | output | 2 | Issuing slot takes an operand by forwarding |

## Verification
A register countdown that is off by one shows up the same cycle a dependent operation is presented. The operation issues a cycle early or late, or it issues without the forwarding flag. A stuck pipe countdown appears as a regular operation or compare held beyond the staging window, or let through inside it. A wrong same-cycle hazard rule shows as slot 1 issuing alongside a producer it depends on. The bench presents dependent chains for every long opcode and compares both output vectors against a behavioural timeline on every clock, so each of these faults surfaces on its first affected cycle.

// File: rtl/fpi_pkg.sv
package fpi_pkg;
  localparam int LAT_W = 5;

  typedef enum logic [3:0] {
    OP_MOV, OP_SGN, OP_CMP, OP_MOVC, OP_ADDSUB, OP_MUL, OP_MADD, OP_CVT,
    OP_DIV_S, OP_DIV_D, OP_SQRT_S, OP_SQRT_D, OP_RCP_S, OP_RCP_D, OP_RSQ_S, OP_RSQ_D
  } fp_op_e;

  typedef enum logic [1:0] {CLS_SHORT, CLS_REG, CLS_LONG} fp_cls_e;

  function automatic fp_cls_e cls_of(logic [3:0] op);
    if (op[3]) return CLS_LONG;
    if (op[2]) return CLS_REG;
    return CLS_SHORT;
  endfunction

  function automatic logic [LAT_W-1:0] lat_of(logic [3:0] op);
    case (op)
      OP_DIV_S, OP_SQRT_S, OP_RCP_D: return LAT_W'(14);
      OP_DIV_D:                      return LAT_W'(20);
      OP_SQRT_D:                     return LAT_W'(23);
      OP_RCP_S, OP_RSQ_S:            return LAT_W'(8);
      OP_RSQ_D:                      return LAT_W'(17);
      default:                       return op[2] ? LAT_W'(4) : LAT_W'(1);
    endcase
  endfunction

  // long ops occupy the pipe three cycles less than their latency
  function automatic logic [LAT_W-1:0] stg_of(logic [3:0] op);
    if (op[3]) return lat_of(op) - LAT_W'(3);
    return LAT_W'(1);
  endfunction

  function automatic logic writes_fpr(logic [3:0] op);
    return op != OP_CMP;
  endfunction
endpackage

// File: rtl/fpi_reg_board.sv
module fpi_reg_board
  import fpi_pkg::*;
#(
  parameter int NP = 2,
  parameter int NR = 32,
  localparam int RW = $clog2(NR)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NP-1:0]             wr_en_i,
  input  logic [NP-1:0][RW-1:0]     wr_idx_i,
  input  logic [NP-1:0][LAT_W-1:0]  wr_lat_i,
  input  logic [NP-1:0]             wr_byp_i,
  output logic [NR-1:0]             ready_o,
  output logic [NR-1:0]             bypok_o
);
  for (genvar r = 0; r < NR; r++) begin : g_reg
    logic [LAT_W-1:0] cnt_q, lat_d;
    logic             byp_q, byp_d, hit;

    always_comb begin
      hit   = 1'b0;
      lat_d = '0;
      byp_d = 1'b0;
      for (int p = 0; p < NP; p++) begin
        if (wr_en_i[p] && wr_idx_i[p] == RW'(r)) begin
          hit   = 1'b1;
          lat_d = wr_lat_i[p];
          byp_d = wr_byp_i[p];
        end
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
        byp_q <= 1'b0;
      end else if (hit) begin
        cnt_q <= lat_d - LAT_W'(1);
        byp_q <= byp_d;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - LAT_W'(1);
      end
    end

    assign ready_o[r] = (cnt_q == '0);
    assign bypok_o[r] = (cnt_q == LAT_W'(1)) && byp_q;

    a_r3_write_blocks_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit && lat_d > LAT_W'(1) |=> !ready_o[r]);
  end
endmodule

// File: rtl/fpi_pipe_stage.sv
module fpi_pipe_stage
  import fpi_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_long_i,
  input  logic [LAT_W-1:0] stg_i,
  output logic             busy_o
);
  logic [LAT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (issue_long_i)      cnt_q <= stg_i - LAT_W'(1);
    else if (cnt_q != '0)       cnt_q <= cnt_q - LAT_W'(1);
  end

  assign busy_o = (cnt_q != '0);

  a_r5_busy_after_long: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_long_i && stg_i > LAT_W'(1) |=> busy_o);
endmodule

// File: rtl/fpi_issue_tracker.sv
module fpi_issue_tracker
  import fpi_pkg::*;
#(
  parameter int NP   = 2,
  parameter int NS   = 3,
  parameter int NR   = 32,
  parameter int CC_W = 3,
  localparam int RW  = $clog2(NR)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NP-1:0]                 vld_i,
  input  logic [NP-1:0][3:0]            op_i,
  input  logic [NP-1:0][NS-1:0][RW-1:0] src_i,
  input  logic [NP-1:0][NS-1:0]         src_en_i,
  input  logic [NP-1:0][RW-1:0]         dst_i,
  input  logic [NP-1:0][CC_W-1:0]       cc_i,
  output logic [NP-1:0]                 issue_o,
  output logic [NP-1:0]                 bypass_o
);
  logic [NR-1:0]            ready, bypok;
  logic [NP-1:0]            busy, wr_en, wr_byp, long_iss;
  logic [NP-1:0][LAT_W-1:0] wr_lat, stg;

  always_comb begin
    logic [NP-1:0] g, b;
    logic          ok, fw;
    g = '0;
    b = '0;
    for (int s = 0; s < NP; s++) begin
      ok = vld_i[s];
      fw = 1'b0;
      if (busy[s] && !(cls_of(op_i[s]) == CLS_SHORT && op_i[s] != OP_CMP)) ok = 1'b0;
      for (int j = 0; j < NS; j++) begin
        if (src_en_i[s][j] && !ready[src_i[s][j]]) begin
          if (bypok[src_i[s][j]]) fw = 1'b1;
          else                    ok = 1'b0;
        end
      end
      if (writes_fpr(op_i[s]) && !ready[dst_i[s]]) ok = 1'b0;
      for (int k = 0; k < s; k++) begin
        if (vld_i[k] && !g[k]) ok = 1'b0;
        if (g[k] && writes_fpr(op_i[k])) begin
          for (int j = 0; j < NS; j++)
            if (src_en_i[s][j] && src_i[s][j] == dst_i[k]) ok = 1'b0;
          if (writes_fpr(op_i[s]) && dst_i[s] == dst_i[k]) ok = 1'b0;
        end
        if (g[k] && op_i[k] == OP_CMP && op_i[s] == OP_MOVC && cc_i[k] == cc_i[s]) ok = 1'b0;
      end
      g[s] = ok;
      b[s] = ok && fw;
    end
    issue_o  = g;
    bypass_o = b;
  end

  for (genvar s = 0; s < NP; s++) begin : g_slot
    assign wr_en[s]    = issue_o[s] && writes_fpr(op_i[s]);
    assign wr_lat[s]   = lat_of(op_i[s]);
    assign wr_byp[s]   = cls_of(op_i[s]) == CLS_REG;
    assign long_iss[s] = issue_o[s] && cls_of(op_i[s]) == CLS_LONG;
    assign stg[s]      = stg_of(op_i[s]);

    fpi_pipe_stage u_pipe (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .issue_long_i(long_iss[s]),
      .stg_i       (stg[s]),
      .busy_o      (busy[s])
    );

    a_r1_issue_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
      issue_o[s] |-> vld_i[s]);
    a_r3_bypass_on_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bypass_o[s] |-> issue_o[s]);
    a_r6_cmp_waits_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      issue_o[s] && op_i[s] == OP_CMP |-> !busy[s]);
  end

  fpi_reg_board #(.NP(NP), .NR(NR)) u_board (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en),
    .wr_idx_i(dst_i),
    .wr_lat_i(wr_lat),
    .wr_byp_i(wr_byp),
    .ready_o (ready),
    .bypok_o (bypok)
  );

  a_r9_in_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o[1] |-> issue_o[0] || !vld_i[0]);
  a_r8_no_same_dst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en[0] && wr_en[1] |-> dst_i[0] != dst_i[1]);
endmodule

// File: tb/tb_fpi_issue_tracker.sv
module tb_fpi_issue_tracker;
  typedef struct packed {
    logic       v;
    logic [3:0] op;
    logic [2:0] en;
    logic [4:0] s2, s1, s0, d;
    logic [2:0] cc;
  } ins_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0]           vld;
  logic [1:0][3:0]      op;
  logic [1:0][2:0][4:0] src;
  logic [1:0][2:0]      en;
  logic [1:0][4:0]      dst;
  logic [1:0][2:0]      cc;
  logic [1:0]           iss, byp;

  int checks = 0, fails = 0, cyc = 0;
  int ready_at[32], byp_at[32], free_at[2];
  ins_t cur[2];

  always #5ns clk = ~clk;

  fpi_issue_tracker dut (
    .clk_i(clk), .rst_ni(rst_n), .vld_i(vld), .op_i(op), .src_i(src),
    .src_en_i(en), .dst_i(dst), .cc_i(cc), .issue_o(iss), .bypass_o(byp)
  );

  function automatic int lat_tb(logic [3:0] o);
    case (o)
      8: return 14;  9: return 20; 10: return 14; 11: return 23;
      12: return 8; 13: return 14; 14: return 8;  15: return 17;
      default: return (o >= 4) ? 4 : 1;
    endcase
  endfunction

  function automatic int stg_tb(logic [3:0] o);
    case (o)
      8: return 11;  9: return 17; 10: return 11; 11: return 20;
      12: return 5; 13: return 11; 14: return 5;  15: return 14;
      default: return 1;
    endcase
  endfunction

  function automatic ins_t mk(int o, int d, int a, int b, int c, int e, int k);
    ins_t x;
    x.v = 1'b1; x.op = 4'(o); x.d = 5'(d); x.s0 = 5'(a); x.s1 = 5'(b); x.s2 = 5'(c);
    x.en = 3'(e); x.cc = 3'(k);
    return x;
  endfunction

  task automatic check(string tag, int act, int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d cycle=%0d", tag, act, exp_v, cyc);
    end
  endtask

  task automatic model_eval(output logic [1:0] ei, output logic [1:0] eb);
    ei = '0; eb = '0;
    for (int s = 0; s < 2; s++) begin
      ins_t x = cur[s];
      logic ok = x.v, fw = 1'b0;
      logic [4:0] sv[3] = '{x.s0, x.s1, x.s2};
      logic wr = (x.op != 2);
      if (s == 1 && cur[0].v && !ei[0]) ok = 1'b0;
      if (cyc < free_at[s] && !(x.op < 4 && x.op != 2)) ok = 1'b0;
      for (int j = 0; j < 3; j++)
        if (x.en[j]) begin
          if (cyc < ready_at[sv[j]]) begin
            if (cyc >= byp_at[sv[j]]) fw = 1'b1; else ok = 1'b0;
          end
        end
      if (wr && cyc < ready_at[x.d]) ok = 1'b0;
      if (s == 1 && ei[0]) begin
        if (cur[0].op != 2) begin
          for (int j = 0; j < 3; j++) if (x.en[j] && sv[j] == cur[0].d) ok = 1'b0;
          if (wr && x.d == cur[0].d) ok = 1'b0;
        end
        if (cur[0].op == 2 && x.op == 3 && cur[0].cc == x.cc) ok = 1'b0;
      end
      ei[s] = ok;
      eb[s] = ok && fw;
    end
  endtask

  task automatic step(string tag, output logic [1:0] ei);
    logic [1:0] eb;
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      vld[k] = cur[k].v; op[k] = cur[k].op; en[k] = cur[k].en; dst[k] = cur[k].d;
      cc[k] = cur[k].cc; src[k][0] = cur[k].s0; src[k][1] = cur[k].s1; src[k][2] = cur[k].s2;
    end
    #1ns;
    model_eval(ei, eb);
    check({tag, " issue"}, int'(iss), int'(ei));
    check({tag, " bypass"}, int'(byp), int'(eb));
    for (int s = 0; s < 2; s++)
      if (ei[s]) begin
        int l = lat_tb(cur[s].op);
        if (cur[s].op != 2) begin
          ready_at[cur[s].d] = cyc + l;
          byp_at[cur[s].d]   = (cur[s].op >= 4 && cur[s].op < 8) ? cyc + l - 1 : cyc + l;
        end
        if (cur[s].op >= 8) free_at[s] = cyc + stg_tb(cur[s].op);
      end
    cyc++;
  endtask

  task automatic run(ins_t a, ins_t b, string tag, output int n, output logic [1:0] first,
                     output logic [1:0] byp_last);
    logic [1:0] pend, ei;
    pend = {b.v, a.v};
    n = 0;
    first = '0;
    byp_last = '0;
    while (pend != 0 && n < 200) begin
      cur[0] = pend[0] ? a : '0;
      cur[1] = pend[1] ? b : '0;
      step(tag, ei);
      if (n == 0) first = iss;
      if (iss != 0) byp_last = byp;
      pend &= ~ei;
      n++;
    end
    cur[0] = '0; cur[1] = '0;
  endtask

  initial begin
    #2ms;
    fails++;
    $display("FAIL R1 watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    logic [1:0] f, bl, ei;
    vld = '0; op = '0; src = '0; en = '0; dst = '0; cc = '0;
    for (int r = 0; r < 32; r++) begin ready_at[r] = 0; byp_at[r] = 0; end
    free_at[0] = 0; free_at[1] = 0;
    cur[0] = '0; cur[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    step("R1 idle", ei);
    run(mk(0, 30, 31, 29, 28, 7, 0), mk(1, 27, 26, 25, 24, 7, 0), "R1 fresh", n, f, bl);
    check("R1 immediate issue cycles", n, 1);

    // R2 short latency
    run(mk(0, 1, 2, 0, 0, 1, 0), '0, "R2 prod", n, f, bl);
    run(mk(1, 3, 1, 0, 0, 1, 0), '0, "R2 dep", n, f, bl);
    check("R2 short dependent cycles", n, 1);

    // R3 regular with forwarding
    run(mk(4, 4, 2, 3, 0, 3, 0), '0, "R3 prod", n, f, bl);
    run(mk(6, 5, 4, 2, 3, 7, 0), '0, "R3 dep", n, f, bl);
    check("R3 regular dependent cycles", n, 3);
    check("R3 bypass flag", int'(bl), 1);

    // R4 long latencies
    for (int o = 8; o < 16; o++) begin
      run(mk(o, 10, 2, 0, 0, 1, 0), '0, "R4 prod", n, f, bl);
      run(mk(0, 11, 10, 0, 0, 1, 0), '0, "R4 dep", n, f, bl);
      check($sformatf("R4 latency op%0d", o), n, lat_tb(4'(o)));
    end

    // R5 staging blocks regular work
    run(mk(9, 20, 1, 0, 0, 1, 0), '0, "R5 long", n, f, bl);
    run(mk(4, 21, 1, 2, 0, 3, 0), '0, "R5 reg", n, f, bl);
    check("R5 staging cycles", n, 17);
    run(mk(12, 22, 1, 0, 0, 1, 0), '0, "R5 long2", n, f, bl);
    run(mk(13, 23, 1, 0, 0, 1, 0), '0, "R5 long3", n, f, bl);
    check("R5 long after long", n, 5);

    // R6 moves slip, compares wait
    repeat (12) step("R6 drain", ei);
    run(mk(10, 24, 1, 0, 0, 1, 0), '0, "R6 long", n, f, bl);
    run(mk(1, 25, 1, 0, 0, 1, 0), '0, "R6 move", n, f, bl);
    check("R6 move during long", n, 1);
    run(mk(2, 0, 1, 2, 0, 3, 4), '0, "R6 cmp", n, f, bl);
    check("R6 compare waits", n, 10);

    // R7 destination pending
    repeat (25) step("R7 drain", ei);
    run(mk(8, 7, 1, 0, 0, 1, 0), '0, "R7 long", n, f, bl);
    // R9 slot1 blocked behind slot0
    run(mk(0, 7, 1, 0, 0, 1, 0), mk(0, 8, 1, 0, 0, 1, 0), "R9 order", n, f, bl);
    check("R7 dest wait cycles", n, 14);
    check("R9 slot1 held first cycle", int'(f), 0);

    // R8 same-cycle hazards
    repeat (12) step("R8 drain", ei);
    run(mk(4, 5, 1, 2, 0, 3, 0), mk(0, 6, 5, 0, 0, 1, 0), "R8 raw", n, f, bl);
    check("R8 same cycle raw cycles", n, 4);
    check("R8 raw slot1 bypass", int'(bl), 2);
    run(mk(2, 0, 1, 2, 0, 3, 3), mk(3, 12, 1, 0, 0, 1, 3), "R8 cc", n, f, bl);
    check("R8 cc hazard cycles", n, 2);
    run(mk(2, 0, 1, 2, 0, 3, 3), mk(3, 13, 1, 0, 0, 1, 5), "R8 cc other", n, f, bl);
    check("R8 cc distinct bits", n, 1);

    // R10 disabled sources ignored
    run(mk(11, 9, 1, 0, 0, 1, 0), '0, "R10 long", n, f, bl);
    run(mk(0, 14, 9, 1, 9, 2, 0), '0, "R10 masked", n, f, bl);
    check("R10 masked source cycles", n, 1);

    // random traffic, every cycle against the timeline
    repeat (30) step("R1 drain", ei);
    cur[0] = '0; cur[1] = '0;
    for (int t = 0; t < 3000; t++) begin
      for (int k = 0; k < 2; k++)
        if (!cur[k].v && ($urandom % 4 != 0)) begin
          int o = ($urandom % 3 == 0) ? 8 + $urandom % 8 : $urandom % 8;
          cur[k] = mk(o, $urandom % 8, $urandom % 8, $urandom % 8, $urandom % 8,
                      $urandom % 8, $urandom % 4);
        end
      step("R2-mix", ei);
      for (int k = 0; k < 2; k++) if (ei[k]) cur[k] = '0;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule